// File: doc/BRIEF.md
# Thermal Alarm Event Generator

This block watches a stream of signed temperature samples and sorts each one against three programmable limits: the top of an alarm window, the bottom of that window, and a critical limit. Each limit has its own trip flag, and each flag uses a selectable hysteresis band so that it does not chatter around its threshold. The three flags are shown directly as status bits. They also drive one event pin, which works in one of three ways: as a comparator that follows the flags, as an interrupt latch that software releases, or in a critical-only mode that reacts to the critical limit alone.

Samples arrive on a valid/ready input. A sample is taken on a rising clock edge where both valid and ready are high. Ready goes low only while the block is in shutdown. A source that sees ready low must hold its sample, or drop it, until ready returns. In shutdown, no sample is taken and the event pin is frozen. A shutdown request is refused while either lock bit is set.

The temperature is 16-bit two's complement with 0.0625 °C per LSB. A resolution select clears the low bits that a coarser conversion would not produce.

Top module: `thermal_event_gen`

## Requirements
- R1: `st_above` sets on a taken sample greater than `lim_upper`. It clears on a taken sample less than or equal to `lim_upper` minus the hysteresis. Any other sample leaves it unchanged.
- R2: `st_below` sets on a taken sample less than `lim_lower` minus the hysteresis. It clears on a taken sample greater than or equal to `lim_lower`. Any other sample leaves it unchanged.
- R3: `st_crit` sets on a taken sample greater than `lim_crit`. It clears on a taken sample strictly less than `lim_crit` minus the hysteresis. Any other sample leaves it unchanged.
- R4: `hys_sel` codes 0, 1, 2 and 3 give a hysteresis of 0, 24, 48 and 96 LSB (0, 1.5, 3 and 6 °C).
- R5: `res_sel` values 0, 1, 2 and 3 select 9, 10, 11 and 12 bits. Before any comparison, the lowest 3, 2, 1 and 0 bits of the sample are cleared.
- R6: Comparator mode is `mode_int`=0 with `mode_crit_only`=0. In this mode the event is active exactly while any of the three flags is set, and `clr_evt` has no effect on the pin.
- R7: Interrupt mode is `mode_int`=1 with `mode_crit_only`=0. In this mode, a 0-to-1 change of `st_above` or `st_below` makes the event active. It stays active until a `clr_evt` pulse, even while the flag remains set.
- R8: While `st_crit` is set, the event is active in every mode, and `clr_evt` cannot release it.
- R9: With `mode_crit_only`=1, only `st_crit` makes the event active. The window flags have no effect on the pin.
- R10: The pin is active-low when `evt_pol_high`=0 and active-high when it is 1. With `evt_en`=0, the pin sits at its inactive level, which is 1 for active-low and 0 for active-high.
- R11: A `cfg_wr` strobe with `cfg_shdn`=1 enters shutdown only when `lock_win` and `lock_crit` are both 0. A strobe with `cfg_shdn`=0 always leaves shutdown. Without a strobe, the shutdown state does not change.
- R12: In shutdown, `temp_ready` is 0, no sample is taken, the flags hold, and `evt_pin` holds its level even when the configuration changes.
- R13: The status flags do not depend on `evt_en`, `evt_pol_high`, `clr_evt` or the event mode.
- R14: The pin reflects a taken sample two clock edges after the edge that takes it. After reset, the flags are 0, `evt_pin` is 1 and `temp_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_valid | input | 1 | Sample valid |
| temp_ready | output | 1 | Sample ready (low in shutdown) |
| temp_data | input | 16 | Two's complement temperature, 0.0625 °C/LSB |
| res_sel | input | 2 | Resolution select (9 to 12 bits) |
| lim_upper | input | 16 | Upper alarm boundary |
| lim_lower | input | 16 | Lower alarm boundary |
| lim_crit | input | 16 | Critical limit |
| hys_sel | input | 2 | Hysteresis code |
| mode_int | input | 1 | 1 = interrupt mode, 0 = comparator mode |
| mode_crit_only | input | 1 | Event follows the critical flag only |
| evt_en | input | 1 | Event output enable |
| evt_pol_high | input | 1 | 1 = active-high event pin |
| clr_evt | input | 1 | One-cycle strobe that releases the interrupt latch |
| cfg_wr | input | 1 | Strobe that loads `cfg_shdn` |
| cfg_shdn | input | 1 | Requested shutdown state |
| lock_win | input | 1 | Window lock, blocks entry to shutdown |
| lock_crit | input | 1 | Critical lock, blocks entry to shutdown |
| st_above | output | 1 | Above-window status flag |
| st_below | output | 1 | Below-window status flag |
| st_crit | output | 1 | Critical status flag |
| shdn_active | output | 1 | Shutdown in effect |
| evt_pin | output | 1 | Event pin level with polarity applied |

## Verification
The hardest states to reach are the hold bands. In a hold band, the same sample value gives a different flag depending on where the temperature came from, and the bench can only get there through the history of the sample stream. The stimulus therefore sweeps the temperature up past all three limits and then back down, in steps that do not line up with the resolution grid. It repeats this for every hysteresis code and resolution, while a running bench model of each flag tracks the direction of approach. The interrupt latch, held while its flag stays set, and a critical trip overlapping a cleared latch are each reached by short directed sequences placed after the sweep.

// File: rtl/thev_pkg.sv
`timescale 1ns/1ps
package thev_pkg;

  // Selects the set/clear rule of one trip flag.
  typedef enum logic [1:0] {
    TRIP_ABOVE_LE = 2'd0,  // set above limit, clear at or below limit - hys
    TRIP_BELOW    = 2'd1,  // set below limit - hys, clear at or above limit
    TRIP_ABOVE_LT = 2'd2   // set above limit, clear strictly below limit - hys
  } trip_kind_e;

  localparam int NUM_TRIPS = 3;
  localparam int IDX_ABOVE = 0;
  localparam int IDX_BELOW = 1;
  localparam int IDX_CRIT  = 2;

  function automatic trip_kind_e kind_of(input int idx);
    case (idx)
      IDX_BELOW: return TRIP_BELOW;
      IDX_CRIT:  return TRIP_ABOVE_LT;
      default:   return TRIP_ABOVE_LE;
    endcase
  endfunction

  // Code 0 gives no band; each further code doubles the band.
  function automatic int hys_lsb(input logic [1:0] code, input int unit);
    if (code == 2'd0) return 0;
    return unit << (int'(code) - 1);
  endfunction

endpackage

// File: rtl/thev_resmask.sv
`timescale 1ns/1ps
module thev_resmask #(
  parameter int TEMP_W = 16,
  parameter int RES_W  = 2
) (
  input  logic [TEMP_W-1:0] temp_in,
  input  logic [RES_W-1:0]  res_sel,
  output logic [TEMP_W-1:0] temp_out
);
  localparam int MAX_DROP = (1 << RES_W) - 1;
  localparam logic [RES_W-1:0] MAX_DROP_V = RES_W'(MAX_DROP);

  logic [RES_W-1:0]  drop;
  logic [TEMP_W-1:0] keep;

  always_comb begin
    drop     = MAX_DROP_V - res_sel;
    keep     = {TEMP_W{1'b1}} << drop;
    temp_out = temp_in & keep;
  end
endmodule

// File: rtl/thev_trip.sv
`timescale 1ns/1ps
module thev_trip
  import thev_pkg::*;
#(
  parameter int         TEMP_W = 16,
  parameter int         HYS_W  = 7,
  parameter trip_kind_e KIND   = TRIP_ABOVE_LE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic [TEMP_W-1:0] temp,
  input  logic [TEMP_W-1:0] limit,
  input  logic [HYS_W-1:0]  hys,
  output logic              flag,
  output logic              rise
);
  localparam int W = TEMP_W + 2;

  logic signed [W-1:0] t_w, lim_w, hys_w, low_w;
  logic set_c, clr_c, nxt;

  assign t_w   = W'($signed(temp));
  assign lim_w = W'($signed(limit));
  assign hys_w = $signed(W'(hys));
  assign low_w = lim_w - hys_w;

  generate
    if (KIND == TRIP_BELOW) begin : g_below
      assign set_c = (t_w < low_w);
      assign clr_c = (t_w >= lim_w);
    end else if (KIND == TRIP_ABOVE_LT) begin : g_above_lt
      assign set_c = (t_w > lim_w);
      assign clr_c = (t_w < low_w);
    end else begin : g_above_le
      assign set_c = (t_w > lim_w);
      assign clr_c = (t_w <= low_w);
    end
  endgenerate

  assign nxt = set_c | (flag & ~clr_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      rise <= 1'b0;
    end else begin
      rise <= sample_en & nxt & ~flag;
      if (sample_en) flag <= nxt;
    end
  end
endmodule

// File: rtl/thev_shdn.sv
`timescale 1ns/1ps
module thev_shdn (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic cfg_shdn,
  input  logic lock_any,
  output logic shdn_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shdn_q <= 1'b0;
    end else if (cfg_wr) begin
      if (!cfg_shdn)     shdn_q <= 1'b0;
      else if (!lock_any) shdn_q <= 1'b1;
    end
  end
endmodule

// File: rtl/thev_event.sv
`timescale 1ns/1ps
module thev_event (
  input  logic clk,
  input  logic rst_n,
  input  logic above,
  input  logic below,
  input  logic crit,
  input  logic rise_win,
  input  logic mode_int,
  input  logic crit_only,
  input  logic en,
  input  logic pol_high,
  input  logic clr,
  input  logic frozen,
  output logic pin
);
  logic int_mode, latch_q, act, pin_d;

  assign int_mode = mode_int & ~crit_only;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                latch_q <= 1'b0;
    else if (!en || !int_mode) latch_q <= 1'b0;
    else if (rise_win)         latch_q <= 1'b1;
    else if (clr)              latch_q <= 1'b0;
  end

  always_comb begin
    if (crit_only)     act = crit;
    else if (int_mode) act = crit | latch_q | rise_win;
    else               act = above | below | crit;
    pin_d = en ? (pol_high ? act : ~act) : ~pol_high;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pin <= 1'b1;
    else if (!frozen) pin <= pin_d;
  end
endmodule

// File: rtl/thermal_event_gen.sv
`timescale 1ns/1ps
module thermal_event_gen
  import thev_pkg::*;
#(
  parameter int TEMP_W   = 16,
  parameter int RES_W    = 2,
  parameter int HYS_UNIT = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              temp_valid,
  output logic              temp_ready,
  input  logic [TEMP_W-1:0] temp_data,
  input  logic [RES_W-1:0]  res_sel,
  input  logic [TEMP_W-1:0] lim_upper,
  input  logic [TEMP_W-1:0] lim_lower,
  input  logic [TEMP_W-1:0] lim_crit,
  input  logic [1:0]        hys_sel,
  input  logic              mode_int,
  input  logic              mode_crit_only,
  input  logic              evt_en,
  input  logic              evt_pol_high,
  input  logic              clr_evt,
  input  logic              cfg_wr,
  input  logic              cfg_shdn,
  input  logic              lock_win,
  input  logic              lock_crit,
  output logic              st_above,
  output logic              st_below,
  output logic              st_crit,
  output logic              shdn_active,
  output logic              evt_pin
);
  localparam int HYS_MAX = HYS_UNIT << 2;
  localparam int HYS_W   = $clog2(HYS_MAX + 1);

  logic                 shdn_q, accept;
  logic [TEMP_W-1:0]    temp_m;
  logic [HYS_W-1:0]     hys_val;
  logic [TEMP_W-1:0]    lim_arr [NUM_TRIPS];
  logic [NUM_TRIPS-1:0] flags, rises;

  assign temp_ready  = ~shdn_q;
  assign shdn_active = shdn_q;
  assign accept      = temp_valid & ~shdn_q;
  assign hys_val     = HYS_W'(hys_lsb(hys_sel, HYS_UNIT));

  assign lim_arr[IDX_ABOVE] = lim_upper;
  assign lim_arr[IDX_BELOW] = lim_lower;
  assign lim_arr[IDX_CRIT]  = lim_crit;

  thev_resmask #(.TEMP_W(TEMP_W), .RES_W(RES_W)) mask_i (
    .temp_in (temp_data),
    .res_sel (res_sel),
    .temp_out(temp_m)
  );

  for (genvar gi = 0; gi < NUM_TRIPS; gi++) begin : g_trip
    thev_trip #(.TEMP_W(TEMP_W), .HYS_W(HYS_W), .KIND(kind_of(gi))) trip_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .sample_en(accept),
      .temp     (temp_m),
      .limit    (lim_arr[gi]),
      .hys      (hys_val),
      .flag     (flags[gi]),
      .rise     (rises[gi])
    );
  end

  thev_shdn shdn_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_wr  (cfg_wr),
    .cfg_shdn(cfg_shdn),
    .lock_any(lock_win | lock_crit),
    .shdn_q  (shdn_q)
  );

  thev_event event_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .above    (flags[IDX_ABOVE]),
    .below    (flags[IDX_BELOW]),
    .crit     (flags[IDX_CRIT]),
    .rise_win (rises[IDX_ABOVE] | rises[IDX_BELOW]),
    .mode_int (mode_int),
    .crit_only(mode_crit_only),
    .en       (evt_en),
    .pol_high (evt_pol_high),
    .clr      (clr_evt),
    .frozen   (shdn_q),
    .pin      (evt_pin)
  );

  assign st_above = flags[IDX_ABOVE];
  assign st_below = flags[IDX_BELOW];
  assign st_crit  = flags[IDX_CRIT];
endmodule

// File: rtl/thermal_event_gen_chk.sv
`timescale 1ns/1ps
module thermal_event_gen_chk #(
  parameter int TEMP_W = 16,
  parameter int RES_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              temp_valid,
  input logic              temp_ready,
  input logic [TEMP_W-1:0] temp_data,
  input logic [RES_W-1:0]  res_sel,
  input logic              evt_en,
  input logic              evt_pol_high,
  input logic              cfg_wr,
  input logic              cfg_shdn,
  input logic              lock_win,
  input logic              lock_crit,
  input logic              st_above,
  input logic              st_below,
  input logic              st_crit,
  input logic              shdn_active,
  input logic              evt_pin
);
  AST_FLAGS_HOLD_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(temp_valid && temp_ready) |=> $stable({st_above, st_below, st_crit})); // R12

  AST_PIN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_active |=> $stable(evt_pin)); // R12

  AST_SHDN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_shdn && (lock_win || lock_crit) && !shdn_active) |=> !shdn_active); // R11

  AST_SHDN_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(shdn_active)); // R11

  AST_DISABLED_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_en && !shdn_active) |=> (evt_pin == !$past(evt_pol_high))); // R10

  AST_CRIT_DRIVES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_crit && evt_en && !evt_pol_high && !shdn_active) |=> !evt_pin); // R8
endmodule

bind thermal_event_gen thermal_event_gen_chk #(.TEMP_W(TEMP_W), .RES_W(RES_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .temp_valid(temp_valid), .temp_ready(temp_ready),
  .temp_data(temp_data), .res_sel(res_sel), .evt_en(evt_en),
  .evt_pol_high(evt_pol_high), .cfg_wr(cfg_wr), .cfg_shdn(cfg_shdn),
  .lock_win(lock_win), .lock_crit(lock_crit), .st_above(st_above),
  .st_below(st_below), .st_crit(st_crit), .shdn_active(shdn_active),
  .evt_pin(evt_pin)
);

// File: tb/thermal_event_gen_tb_top.sv
`timescale 1ns/1ps
module thermal_event_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic temp_valid = 1'b0;
  logic temp_ready;
  logic [15:0] temp_data = '0;
  logic [1:0] res_sel = 2'd3;
  logic [15:0] lim_upper = 16'd400;
  logic [15:0] lim_lower = 16'd160;
  logic [15:0] lim_crit  = 16'd800;
  logic [1:0] hys_sel = 2'd0;
  logic mode_int = 1'b0, mode_crit_only = 1'b0, evt_en = 1'b1, evt_pol_high = 1'b0;
  logic clr_evt = 1'b0, cfg_wr = 1'b0, cfg_shdn = 1'b0, lock_win = 1'b0, lock_crit = 1'b0;
  logic st_above, st_below, st_crit, shdn_active, evt_pin;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int m_a = 0, m_b = 0, m_c = 0;

  always #2.5 clk = ~clk;

  thermal_event_gen dut_i (
    .clk(clk), .rst_n(rst_n), .temp_valid(temp_valid), .temp_ready(temp_ready),
    .temp_data(temp_data), .res_sel(res_sel), .lim_upper(lim_upper),
    .lim_lower(lim_lower), .lim_crit(lim_crit), .hys_sel(hys_sel),
    .mode_int(mode_int), .mode_crit_only(mode_crit_only), .evt_en(evt_en),
    .evt_pol_high(evt_pol_high), .clr_evt(clr_evt), .cfg_wr(cfg_wr),
    .cfg_shdn(cfg_shdn), .lock_win(lock_win), .lock_crit(lock_crit),
    .st_above(st_above), .st_below(st_below), .st_crit(st_crit),
    .shdn_active(shdn_active), .evt_pin(evt_pin)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input int t);
    @(negedge clk); temp_valid = 1'b1; temp_data = 16'(t);
    @(negedge clk); temp_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_evt = 1'b1;
    @(negedge clk); clr_evt = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic cfg_write(input logic s);
    @(negedge clk); cfg_wr = 1'b1; cfg_shdn = s;
    @(negedge clk); cfg_wr = 1'b0;
    @(negedge clk);
  endtask

  // Bench model of the three flags from R1..R5, R4 band = 0/24/48/96.
  task automatic model_step(input int t, input int res, input int hy);
    int drop = 3 - res;
    int h = (hy == 0) ? 0 : (24 << (hy - 1));
    int tm = (t >>> drop) <<< drop;
    if (tm > 400) m_a = 1; else if (tm <= 400 - h) m_a = 0;
    if (tm < 160 - h) m_b = 1; else if (tm >= 160) m_b = 0;
    if (tm > 800) m_c = 1; else if (tm < 800 - h) m_c = 0;
  endtask

  task automatic sweep_point(input int t, input int res, input int hy);
    push(t);
    model_step(t, res, hy);
    check("R1 R2 R3 R4 R5 flags", int'({st_above, st_below, st_crit}), (m_a << 2) | (m_b << 1) | m_c);
    check("R6 comparator pin", int'(evt_pin), (m_a | m_b | m_c) ? 0 : 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R14 reset state
    check("R14 reset flags", int'({st_above, st_below, st_crit}), 0);
    check("R14 reset pin", int'(evt_pin), 1);
    check("R14 reset ready", int'(temp_ready), 1);

    // Sweeps over every resolution and hysteresis code, rising then falling.
    for (int res = 0; res < 4; res++) begin
      for (int hy = 0; hy < 4; hy++) begin
        res_sel = 2'(res); hys_sel = 2'(hy);
        for (int t = -100; t <= 1000; t += 5) sweep_point(t, res, hy);
        for (int t = 1000; t >= -100; t -= 5) sweep_point(t, res, hy);
      end
    end

    res_sel = 2'd3; hys_sel = 2'd0;
    push(300);
    check("R1 R2 R3 inside window", int'({st_above, st_below, st_crit}), 0);

    // R7 interrupt latch
    mode_int = 1'b1;
    push(300); check("R7 idle pin", int'(evt_pin), 1);
    push(500); check("R7 latch set", int'(evt_pin), 0);
    pulse_clr(); check("R7 clear releases", int'(evt_pin), 1);
    push(500); check("R7 no new edge", int'(evt_pin), 1);
    check("R13 flag kept after clear", int'(st_above), 1);
    push(300); check("R7 flag leaves", int'(evt_pin), 1);
    push(500); check("R7 second edge", int'(evt_pin), 0);
    pulse_clr(); check("R7 clear again", int'(evt_pin), 1);

    // R8 critical overrides interrupt clear
    push(900); check("R8 crit active", int'(evt_pin), 0);
    pulse_clr(); check("R8 clear ignored", int'(evt_pin), 0);
    push(500); check("R8 crit gone", int'(evt_pin), 1);

    // R6 comparator ignores clear
    mode_int = 1'b0;
    repeat (2) @(negedge clk);
    check("R6 comparator follows flag", int'(evt_pin), 0);
    pulse_clr(); check("R6 clear no effect", int'(evt_pin), 0);
    push(300); check("R6 self clear", int'(evt_pin), 1);

    // R9 critical-only
    mode_crit_only = 1'b1; hys_sel = 2'd3;
    push(0);
    check("R9 below flag set", int'(st_below), 1);
    check("R9 window ignored", int'(evt_pin), 1);
    push(900); check("R9 crit asserts", int'(evt_pin), 0);
    push(790); check("R9 hold in band", int'(evt_pin), 0);
    push(700);
    check("R9 released below band", int'(evt_pin), 1);
    check("R9 above flag still set", int'(st_above), 1);
    mode_crit_only = 1'b0; hys_sel = 2'd0;
    push(300);

    // R10 enable and polarity, R13 flags independent
    evt_en = 1'b0;
    push(900);
    check("R10 disabled low-active inactive", int'(evt_pin), 1);
    check("R13 crit flag while disabled", int'(st_crit), 1);
    evt_pol_high = 1'b1; repeat (2) @(negedge clk);
    check("R10 disabled high-active inactive", int'(evt_pin), 0);
    evt_en = 1'b1; repeat (2) @(negedge clk);
    check("R10 active-high asserted", int'(evt_pin), 1);
    evt_pol_high = 1'b0; repeat (2) @(negedge clk);
    check("R10 active-low asserted", int'(evt_pin), 0);
    push(300);
    check("R10 idle", int'(evt_pin), 1);

    // R5 resolution masking
    res_sel = 2'd0; push(407);
    check("R5 9-bit drops low bits", int'(st_above), 0);
    res_sel = 2'd3; push(407);
    check("R5 12-bit keeps low bits", int'(st_above), 1);
    push(300);

    // R11 shutdown lock, R12 freeze
    lock_win = 1'b1; cfg_write(1'b1);
    check("R11 window lock blocks", int'(shdn_active), 0);
    lock_win = 1'b0; lock_crit = 1'b1; cfg_write(1'b1);
    check("R11 crit lock blocks", int'(shdn_active), 0);
    lock_crit = 1'b0; cfg_write(1'b1);
    check("R11 shutdown entered", int'(shdn_active), 1);
    check("R12 ready low", int'(temp_ready), 0);
    @(negedge clk); temp_valid = 1'b1; temp_data = 16'd900;
    repeat (5) @(negedge clk);
    temp_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R12 sample refused", int'(st_crit), 0);
    evt_pol_high = 1'b1; repeat (3) @(negedge clk);
    check("R12 pin frozen", int'(evt_pin), 1);
    lock_win = 1'b1; cfg_write(1'b0);
    check("R11 exit under lock", int'(shdn_active), 0);
    repeat (2) @(negedge clk);
    check("R12 pin resumes", int'(evt_pin), 0);
    check("R12 ready back", int'(temp_ready), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R14 actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule